// File: doc/BRIEF.md
# Trimmed Seconds Real-Time Counter

This block keeps a 32-bit count of elapsed seconds. The time base comes from one of two strobe inputs, both in the system clock domain. One is a raw low-frequency strobe at the nominal 32.768 kHz rate. The other is a fast strobe at 4.194304 MHz, which the block divides by a power of two (128 by default) to reach the same nominal rate.

A predivider turns time-base ticks into a one-second pulse. Each pulse advances the seconds counter. To correct the rate, the predivider uses a programmable trim value as its terminal count during one second out of every 2^`TRIM_LOG2` seconds (64 by default). In every other second it uses the nominal terminal count `NOMINAL` (0x7FFF by default).

Two match registers each own a sticky flag. A flag is set when the counter steps onto the matching value, and software clears it with a write-1-to-clear command. The flags are meant to drive wake and interrupt logic elsewhere. Writes to the load, match and trim registers are paced: a done bit goes low for a short synchronisation window after each one.

Top module: `rtc_trim_seconds`

## Requirements
- R1: After a synchronous active-low reset, the outputs read as follows: `seconds` is 0, both match flags are 0 and `wr_done` is 1. The internal state starts as follows: counting is disabled, the raw strobe is selected, the trim register holds `NOMINAL`, the predivider is 0 and the second index is 0.
- R2: A write with `wr_sel`=0 (control) sets the run bit from `wr_data[0]` and the time-base select from `wr_data[1]`. When the select is 0, every `raw_strobe` is a time-base tick. When the select is 1, every 2^`XDIV_LOG2`-th `xtal_strobe` is a tick, counted since reset. Strobes on the unselected input have no effect.
- R3: With the run bit set, a normal second lasts `NOMINAL`+1 time-base ticks. The seconds counter increments on the edge that samples the last tick of the second.
- R4: A second index counts completed seconds modulo 2^`TRIM_LOG2` and is 0 after reset. The second in which that index is 0 lasts trim+1 ticks. The trim value is written with `wr_sel`=4 from `wr_data[15:0]`.
- R5: While the run bit is 0, the predivider, the second index and the seconds counter do not advance.
- R6: A load write (`wr_sel`=1) sets `seconds` to `wr_data` on the next edge. A load takes priority over an increment in the same cycle, and it does not reset the predivider.
- R7: Match register 0 is written with `wr_sel`=2 and match register 1 with `wr_sel`=3. Match flag i (bit i of `match_flag`) is set only when an increment makes the counter equal to match register i. Loading a value that equals a match register does not set its flag.
- R8: Match flags stay set until a clear write (`wr_sel`=5) has a 1 in `wr_data[i]` for flag i. If a match and a clear happen in the same cycle, the flag is set.
- R9: An accepted load, match or trim write drives `wr_done` low for 3 cycles. A load, match or trim write issued while `wr_done` is 0 is ignored.
- R10: The seconds counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_strobe | input | 1 | Low-frequency time-base strobe |
| xtal_strobe | input | 1 | Fast time-base strobe, divided internally |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1 load, 2 match0, 3 match1, 4 trim, 5 clear |
| wr_data | input | 32 | Write data |
| seconds | output | 32 | Current seconds count |
| match_flag | output | 2 | Sticky match flags, bit i for match register i |
| wr_done | output | 1 | High when a paced write may be issued |

## Verification
The seconds count and the match flags change on the same edge that samples the final time-base strobe of a second, so the bench reads them on the falling edge after that strobe. A load or match write takes effect on the edge that samples it. `wr_done` reads 0 at the first, second and third falling edges after an accepted paced write, and it reads 1 at the fourth. The bench checks each of those four points and sends a second write inside the window to show it is dropped. Every tick pulse lasts one cycle and is followed by an idle cycle, so the bench can count predivider positions exactly. That makes the trim second and the wrap from the top value predictable.

// File: rtl/rtc_pkg.sv
// Shared definitions for the trimmed seconds counter.
// Assumes: the write-select encoding below is fixed, because software uses it.
package rtc_pkg;
    localparam int NUM_MATCH = 2;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_LOAD   = 3'd1,
        SEL_MATCH0 = 3'd2,
        SEL_MATCH1 = 3'd3,
        SEL_TRIM   = 3'd4,
        SEL_CLEAR  = 3'd5
    } wsel_e;
endpackage

// File: rtl/rtc_timebase.sv
// Time-base selector: passes the raw strobe through, or divides the fast
// strobe by 2^XDIV_LOG2.
// Assumes: both strobes are single-cycle pulses in the clk domain.
module rtc_timebase #(
    parameter int XDIV_LOG2 = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_xtal,
    input  logic raw_strobe,
    input  logic xtal_strobe,
    output logic tb_tick
);
    logic [XDIV_LOG2-1:0] xdiv_q;
    logic                 xtal_tick;

    // Free-running fast-strobe divider.
    always_ff @(posedge clk) begin
        if (!rst_n)           xdiv_q <= '0;
        else if (xtal_strobe) xdiv_q <= xdiv_q + 1'b1;
    end

    assign xtal_tick = xtal_strobe && (xdiv_q == '1);
    assign tb_tick   = use_xtal ? xtal_tick : raw_strobe;

    // R2: a divided tick always comes from a fast strobe.
    a_r2_div_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (use_xtal && tb_tick) |-> xtal_strobe);
endmodule

// File: rtl/rtc_prediv.sv
// Predivider: counts time-base ticks up to a terminal value and emits one
// pulse per second. The terminal value is the trim value in the second whose
// index is 0, and NOMINAL in every other second.
// Assumes: tb_tick is a single-cycle pulse.
module rtc_prediv #(
    parameter int          PW        = 16,
    parameter int          TRIM_LOG2 = 6,
    parameter logic [15:0] NOMINAL   = 16'h7FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tb_tick,
    input  logic [PW-1:0] trim,
    output logic          sec_tick
);
    logic [PW-1:0]        prediv_q;
    logic [TRIM_LOG2-1:0] idx_q;
    logic [PW-1:0]        term;

    assign term     = (idx_q == '0) ? trim : NOMINAL[PW-1:0];
    assign sec_tick = run && tb_tick && (prediv_q >= term);

    // Advance the predivider and the second index on counted ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prediv_q <= '0;
            idx_q    <= '0;
        end else if (run && tb_tick) begin
            if (sec_tick) begin
                prediv_q <= '0;
                idx_q    <= idx_q + 1'b1;
            end else begin
                prediv_q <= prediv_q + 1'b1;
            end
        end
    end

    // R5: nothing moves while stopped.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(prediv_q) && $stable(idx_q)));
    // R4: the second index steps by one per second, modulo 2^TRIM_LOG2.
    a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (idx_q == $past(idx_q) + TRIM_LOG2'(1)));
endmodule

// File: rtl/rtc_wpace.sv
// Write pacer: after each accepted paced write, holds done low for PACE
// cycles. Requests made while done is low are refused.
// Assumes: req is already qualified with the paced register selects.
module rtc_wpace #(
    parameter int PACE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic done
);
    localparam int CW = $clog2(PACE + 1);
    logic [CW-1:0] cnt_q;

    assign done   = (cnt_q == '0);
    assign accept = req && done;

    // Load the window on accept, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (accept)         cnt_q <= CW'(PACE);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // R9: the window opens right after an accepted write.
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !done);
    // R9: the window closes one step at a time.
    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rtc_match.sv
// One match unit: a value register and a sticky flag. The flag is set when
// the counter steps onto the value and cleared by a clear command.
// Assumes: step is high only in the cycle the counter increments to next_value.
module rtc_match #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_match,
    input  logic [SW-1:0] wr_value,
    input  logic          step,
    input  logic [SW-1:0] next_value,
    input  logic          clr,
    output logic          flag
);
    logic [SW-1:0] match_q;
    logic          flag_q;
    logic          hit;

    assign hit  = step && (next_value == match_q);
    assign flag = flag_q;

    // Hold the match value.
    always_ff @(posedge clk) begin
        if (!rst_n)        match_q <= '0;
        else if (wr_match) match_q <= wr_value;
    end

    // Sticky flag; a hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // R8: the flag stays set until it is cleared.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    // R7: the flag is only raised by an increment.
    a_r7_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !step) |=> !flag_q);
endmodule

// File: rtl/rtc_trim_seconds.sv
// Trimmed seconds counter top level: decodes register writes, paces the
// load, match and trim writes, and joins the time base, the predivider,
// the seconds counter and the match units.
// Assumes: every input is synchronous to clk.
module rtc_trim_seconds
    import rtc_pkg::*;
#(
    parameter int          SW        = 32,
    parameter int          PW        = 16,
    parameter int          TRIM_LOG2 = 6,
    parameter int          XDIV_LOG2 = 7,
    parameter int          PACE      = 3,
    parameter logic [15:0] NOMINAL   = 16'h7FFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 raw_strobe,
    input  logic                 xtal_strobe,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [SW-1:0]        wr_data,
    output logic [SW-1:0]        seconds,
    output logic [NUM_MATCH-1:0] match_flag,
    output logic                 wr_done
);
    logic          run_q, xsel_q;
    logic [PW-1:0] trim_q;
    logic [SW-1:0] seconds_q;
    logic          paced_sel, paced_req, accept;
    logic          load_acc, trim_acc, ctrl_wr, clr_wr;
    logic          tb_tick, sec_tick, step;

    assign paced_sel = (wr_sel == SEL_LOAD) || (wr_sel == SEL_MATCH0) ||
                       (wr_sel == SEL_MATCH1) || (wr_sel == SEL_TRIM);
    assign paced_req = wr_en && paced_sel;
    assign load_acc  = accept && (wr_sel == SEL_LOAD);
    assign trim_acc  = accept && (wr_sel == SEL_TRIM);
    assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
    assign clr_wr    = wr_en && (wr_sel == SEL_CLEAR);
    assign step      = sec_tick && !load_acc;

    rtc_wpace #(.PACE(PACE)) u_pace (
        .clk(clk), .rst_n(rst_n), .req(paced_req),
        .accept(accept), .done(wr_done)
    );

    rtc_timebase #(.XDIV_LOG2(XDIV_LOG2)) u_tbase (
        .clk(clk), .rst_n(rst_n), .use_xtal(xsel_q),
        .raw_strobe(raw_strobe), .xtal_strobe(xtal_strobe), .tb_tick(tb_tick)
    );

    rtc_prediv #(.PW(PW), .TRIM_LOG2(TRIM_LOG2), .NOMINAL(NOMINAL)) u_prediv (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tb_tick(tb_tick),
        .trim(trim_q), .sec_tick(sec_tick)
    );

    // Control and trim registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            xsel_q <= 1'b0;
            trim_q <= NOMINAL[PW-1:0];
        end else begin
            if (ctrl_wr) begin
                run_q  <= wr_data[0];
                xsel_q <= wr_data[1];
            end
            if (trim_acc) trim_q <= wr_data[PW-1:0];
        end
    end

    // Seconds counter; a load wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)        seconds_q <= '0;
        else if (load_acc) seconds_q <= wr_data;
        else if (step)     seconds_q <= seconds_q + 1'b1;
    end

    assign seconds = seconds_q;

    // One match unit per match register.
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
        rtc_match #(.SW(SW)) u_match (
            .clk(clk), .rst_n(rst_n),
            .wr_match(accept && (wr_sel == 3'(SEL_MATCH0 + i))),
            .wr_value(wr_data),
            .step(step),
            .next_value(seconds_q + 1'b1),
            .clr(clr_wr && wr_data[i]),
            .flag(match_flag[i])
        );
    end

    // R3/R10: an increment adds exactly one, wrapping at the top value.
    a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (seconds_q == $past(seconds_q) + 1'b1));
    // R6: a load lands on the next edge.
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc |=> (seconds_q == $past(wr_data)));
    // R5: a stopped counter only changes by a load.
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_acc) |=> $stable(seconds_q));
endmodule

// File: tb/test_rtc_trim_seconds.sv
module test_rtc_trim_seconds;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  sel;
        logic [31:0] data;
        logic [7:0]  ticks;
        logic [31:0] sec;
        logic [1:0]  flags;
    } vec_t;

    // Bench parameters: NOMINAL=3 (4 ticks per second), trim second every 4 s,
    // fast strobe divided by 4.
    localparam vec_t VECS [9] = '{
        '{3'd0, 32'd1,   8'd8, 32'd2,   2'b00},  // R2 R3 R4: run, raw, two seconds
        '{3'd1, 32'd100, 8'd0, 32'd100, 2'b00},  // R6 load
        '{3'd2, 32'd102, 8'd4, 32'd101, 2'b00},  // R7 match0 set, no hit yet
        '{3'd3, 32'd101, 8'd4, 32'd102, 2'b01},  // R7 match0 hit
        '{3'd4, 32'd1,   8'd2, 32'd103, 2'b01},  // R4 trim second of 2 ticks
        '{3'd5, 32'd1,   8'd4, 32'd104, 2'b00},  // R8 clear flag0
        '{3'd1, 32'd101, 8'd0, 32'd101, 2'b00},  // R7 load equal to match1: no flag
        '{3'd0, 32'd0,   8'd8, 32'd101, 2'b00},  // R5 stopped
        '{3'd0, 32'd3,   8'd8, 32'd101, 2'b00}   // R2 raw ignored in fast mode
    };

    logic        clk = 0, rst_n = 0, raw_strobe = 0, xtal_strobe = 0, wr_en = 0;
    logic [2:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] seconds;
    logic [1:0]  match_flag;
    logic        wr_done;
    int          n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_trim_seconds #(.TRIM_LOG2(2), .XDIV_LOG2(2), .NOMINAL(16'd3)) i_rtc_trim_seconds (
        .clk(clk), .rst_n(rst_n), .raw_strobe(raw_strobe), .xtal_strobe(xtal_strobe),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .seconds(seconds), .match_flag(match_flag), .wr_done(wr_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [31:0] data);
        while (!wr_done) @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic raw_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            raw_strobe = 1; @(negedge clk);
            raw_strobe = 0; @(negedge clk);
        end
    endtask

    task automatic xtal_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            xtal_strobe = 1; @(negedge clk);
            xtal_strobe = 0; @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 seconds", seconds, 0);
        check("R1 flags", {30'd0, match_flag}, 0);
        check("R1 wr_done", {31'd0, wr_done}, 1);

        for (int v = 0; v < 9; v++) begin
            do_write(VECS[v].sel, VECS[v].data);
            raw_pulses(VECS[v].ticks);
            check($sformatf("R3 vector %0d seconds", v), seconds, VECS[v].sec);
            check($sformatf("R8 vector %0d flags", v), {30'd0, match_flag}, {30'd0, VECS[v].flags});
        end

        // R2: fast strobe divided by 4, nominal second -> 16 strobes; hits match0=102 (R7)
        xtal_pulses(16);
        check("R2 fast mode seconds", seconds, 102);
        check("R7 fast mode flag", {30'd0, match_flag}, 1);

        // R9: pacing window and ignored second write
        while (!wr_done) @(negedge clk);
        wr_en = 1; wr_sel = 3'd1; wr_data = 500;
        @(negedge clk);
        check("R9 done low 1", {31'd0, wr_done}, 0);
        wr_data = 600;
        @(negedge clk);
        wr_en = 0;
        check("R9 done low 2", {31'd0, wr_done}, 0);
        @(negedge clk);
        check("R9 done low 3", {31'd0, wr_done}, 0);
        @(negedge clk);
        check("R9 done back", {31'd0, wr_done}, 1);
        check("R9 busy write ignored", seconds, 500);

        // R10: wrap from the top value
        do_write(3'd1, 32'hFFFF_FFFF);
        xtal_pulses(16);
        check("R10 wrap", seconds, 0);

        // R4: trim second (trim=1) in fast mode lasts 2 ticks = 8 strobes
        xtal_pulses(8);
        check("R4 trim second fast", seconds, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule